// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block turns logical general-register numbers into physical register numbers for a 128-entry, 64-bit register file. The lowest 32 registers are global: they map straight through and are never renamed. The upper 96 form a circular stack of procedure frames. The active frame is described by three fields: a base offset into the 96-entry stacked region, a frame size and a locals size. A logical stacked register r maps to physical `32 + ((base + r - 32) mod 96)`.

Three commands change the frame. An allocate sets the callee's frame size and locals size. A call saves the current frame descriptor on an internal stack of eight entries. It then moves the base up past the caller's locals, so the caller's output registers become the callee's first stacked registers. A return pops the saved descriptor and so restores the caller's mapping. No register data is ever moved. A call with the save stack full raises a one-cycle overflow pulse, and a return with it empty raises an underflow pulse. In both cases the frame is left unchanged. Spilling to memory is up to the surrounding logic.

A small state machine tracks how full the save stack is. It has three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are:
- push-first: `ST_EMPTY` to `ST_PARTIAL` on a call.
- push-fill: `ST_PARTIAL` to `ST_FULL` on the call that stores the last free entry.
- pop-drain: `ST_PARTIAL` to `ST_EMPTY` on the return that removes the last entry.
- pop-unfill: `ST_FULL` to `ST_PARTIAL` on a return.
- overflow-hold: a self-loop in `ST_FULL` on a call.
- underflow-hold: a self-loop in `ST_EMPTY` on a return.

Several lookup ports read the registered frame state combinationally.

Top module: `rnm_frame_renamer`

## Requirements
- R1: A logical register below 32 returns its own number as the physical index and is never flagged illegal, whatever the frame.
- R2: A logical register r with 32 <= r < 32 + size returns physical `32 + ((base + r - 32) mod 96)` and is not flagged illegal.
- R3: A logical register r with r >= 32 + size is flagged illegal and returns physical index 0.
- R4: An allocate (op code 3) whose locals size is no more than its frame size, and whose frame size is no more than 96, loads both fields on the next edge. The frame marker output places the fields as follows: frame size in bits [6:0], locals size in [13:7], base in [20:14]. All other bits are zero.
- R5: An allocate whose locals size exceeds its frame size, or whose frame size exceeds 96, leaves the frame marker unchanged.
- R6: A call (op code 1) with a free save entry sets base to (base + locals) mod 96, frame size to size - locals, and locals to 0. Each caller output register 32 + locals + k then resolves to the same physical register as the callee's register 32 + k.
- R7: A return (op code 2) restores the most recently saved frame marker exactly, in last-in first-out order.
- R8: A call while eight markers are saved raises the overflow output for exactly one cycle and leaves the frame marker unchanged.
- R9: A return while no marker is saved raises the underflow output for exactly one cycle and leaves the frame marker unchanged.
- R10: After reset the frame marker is zero and both flags are low.
- R11: Lookups reflect the registered frame. A command presented in a cycle affects lookups only after the next rising edge. Op code 0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op_i | input | 2 | Command: 0 none, 1 call, 2 return, 3 allocate |
| cmd_size_i | input | 7 | Frame size for allocate |
| cmd_locals_i | input | 7 | Locals size for allocate |
| lk_lreg_i | input | NUM_PORTS*7 | Logical register per lookup port, port 0 in the low bits |
| lk_preg_o | output | NUM_PORTS*7 | Physical register per lookup port |
| lk_illegal_o | output | NUM_PORTS | Lookup addresses a stacked register outside the frame |
| cfm_o | output | 64 | Current frame marker |
| overflow_o | output | 1 | Call rejected, save stack full (one-cycle pulse) |
| underflow_o | output | 1 | Return rejected, save stack empty (one-cycle pulse) |

## Verification
The assertions rely on two properties of the inputs. First, the two-bit op code carries exactly one command per cycle. Second, locals never exceed the frame size; the block keeps this true itself by rejecting bad allocates, so the call property can subtract locals from size safely. The bench deliberately offers out-of-range allocate arguments, to show they are rejected. It otherwise issues only legal sequences. It nests calls eight deep so the base wraps past 96, provokes exactly one overflow and one underflow, and sweeps every logical register on two ports after each frame change.

// File: rtl/rnm_pkg.sv
`timescale 1ns/1ps
package rnm_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_CALL  = 2'd1,
        OP_RET   = 2'd2,
        OP_ALLOC = 2'd3
    } rnm_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } rnm_state_e;
endpackage

// File: rtl/rnm_save_stack.sv
`timescale 1ns/1ps
module rnm_save_stack #(
    parameter int DEPTH   = 8,
    parameter int ENTRY_W = 21,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [ENTRY_W-1:0] wdata_i,
    output logic [ENTRY_W-1:0] rdata_o,
    output logic [CNT_W-1:0]   count_o
);
    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic [AW-1:0]      wr_idx;
    logic [AW-1:0]      top_idx;

    assign wr_idx  = AW'(cnt_q);
    assign top_idx = AW'(cnt_q - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            slots[wr_idx] <= wdata_i;
        end
    end

    assign rdata_o = (cnt_q == '0) ? '0 : slots[top_idx];
    assign count_o = cnt_q;
endmodule

// File: rtl/rnm_frame_ctrl.sv
`timescale 1ns/1ps
module rnm_frame_ctrl
    import rnm_pkg::*;
#(
    parameter int NUM_STACKED = 96,
    parameter int IW          = 7,
    parameter int SAVE_DEPTH  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rnm_op_e       op_i,
    input  logic [IW-1:0] arg_size_i,
    input  logic [IW-1:0] arg_loc_i,
    output logic [IW-1:0] base_o,
    output logic [IW-1:0] size_o,
    output logic [IW-1:0] loc_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int ENTRY_W = 3 * IW;
    localparam int CNT_W   = $clog2(SAVE_DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAVE_DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam logic [IW:0]      STK_EXT  = (IW + 1)'(NUM_STACKED);
    localparam logic [IW-1:0]    STK_MAX  = IW'(NUM_STACKED);

    rnm_state_e state_q, state_d;

    logic [IW-1:0]      base_q, size_q, loc_q;
    logic               ovf_q, unf_q;
    logic               do_push, do_pop, alloc_ok;
    logic               ovf_d, unf_d;
    logic [IW:0]        base_sum;
    logic [IW-1:0]      base_next;
    logic [ENTRY_W-1:0] top_entry;
    logic [CNT_W-1:0]   depth;

    rnm_save_stack #(
        .DEPTH   (SAVE_DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (do_push),
        .pop_i   (do_pop),
        .wdata_i ({base_q, loc_q, size_q}),
        .rdata_o (top_entry),
        .count_o (depth)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op_i == OP_CALL) begin
                    state_d = (SAVE_DEPTH == 1) ? ST_FULL : ST_PARTIAL;   // push-first
                end
            end
            ST_PARTIAL: begin
                if (op_i == OP_CALL && depth == LAST_CNT) begin
                    state_d = ST_FULL;                                    // push-fill
                end else if (op_i == OP_RET && depth == ONE_CNT) begin
                    state_d = ST_EMPTY;                                   // pop-drain
                end
            end
            ST_FULL: begin
                if (op_i == OP_RET) begin
                    state_d = (SAVE_DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;  // pop-unfill
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Output / command decode
    always_comb begin
        do_push  = (op_i == OP_CALL)  && (state_q != ST_FULL);
        do_pop   = (op_i == OP_RET)   && (state_q != ST_EMPTY);
        ovf_d    = (op_i == OP_CALL)  && (state_q == ST_FULL);
        unf_d    = (op_i == OP_RET)   && (state_q == ST_EMPTY);
        alloc_ok = (op_i == OP_ALLOC) && (arg_size_i <= STK_MAX)
                   && (arg_loc_i <= arg_size_i);
        base_sum  = {1'b0, base_q} + {1'b0, loc_q};
        base_next = (base_sum >= STK_EXT) ? IW'(base_sum - STK_EXT) : IW'(base_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            loc_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
            unf_q <= unf_d;
            if (do_push) begin
                base_q <= base_next;
                size_q <= size_q - loc_q;
                loc_q  <= '0;
            end else if (do_pop) begin
                {base_q, loc_q, size_q} <= top_entry;
            end else if (alloc_ok) begin
                size_q <= arg_size_i;
                loc_q  <= arg_loc_i;
            end
        end
    end

    assign base_o = base_q;
    assign size_o = size_q;
    assign loc_o  = loc_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;
endmodule

// File: rtl/rnm_lookup.sv
`timescale 1ns/1ps
module rnm_lookup #(
    parameter int NUM_GLOBAL  = 32,
    parameter int NUM_STACKED = 96,
    parameter int IW          = 7
) (
    input  logic [IW-1:0] lreg_i,
    input  logic [IW-1:0] base_i,
    input  logic [IW-1:0] size_i,
    output logic [IW-1:0] preg_o,
    output logic          illegal_o
);
    localparam logic [IW-1:0] G_IDX   = IW'(NUM_GLOBAL);
    localparam logic [IW:0]   STK_EXT = (IW + 1)'(NUM_STACKED);

    logic [IW-1:0] off;
    logic [IW:0]   sum;
    logic [IW-1:0] wrapped;

    always_comb begin
        off     = lreg_i - G_IDX;
        sum     = {1'b0, base_i} + {1'b0, off};
        wrapped = (sum >= STK_EXT) ? IW'(sum - STK_EXT) : IW'(sum);
        if (lreg_i < G_IDX) begin
            preg_o    = lreg_i;
            illegal_o = 1'b0;
        end else if (off >= size_i) begin
            preg_o    = '0;
            illegal_o = 1'b1;
        end else begin
            preg_o    = G_IDX + wrapped;
            illegal_o = 1'b0;
        end
    end
endmodule

// File: rtl/rnm_frame_renamer.sv
`timescale 1ns/1ps
module rnm_frame_renamer
    import rnm_pkg::*;
#(
    parameter int NUM_REGS   = 128,
    parameter int NUM_GLOBAL = 32,
    parameter int SAVE_DEPTH = 8,
    parameter int NUM_PORTS  = 2,
    parameter int MARKER_W   = 64,
    localparam int IW        = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cmd_op_i,
    input  logic [IW-1:0]           cmd_size_i,
    input  logic [IW-1:0]           cmd_locals_i,
    input  logic [NUM_PORTS*IW-1:0] lk_lreg_i,
    output logic [NUM_PORTS*IW-1:0] lk_preg_o,
    output logic [NUM_PORTS-1:0]    lk_illegal_o,
    output logic [MARKER_W-1:0]     cfm_o,
    output logic                    overflow_o,
    output logic                    underflow_o
);
    localparam int NUM_STACKED = NUM_REGS - NUM_GLOBAL;

    logic [IW-1:0] base, size, locs;

    rnm_frame_ctrl #(
        .NUM_STACKED (NUM_STACKED),
        .IW          (IW),
        .SAVE_DEPTH  (SAVE_DEPTH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (rnm_op_e'(cmd_op_i)),
        .arg_size_i (cmd_size_i),
        .arg_loc_i  (cmd_locals_i),
        .base_o     (base),
        .size_o     (size),
        .loc_o      (locs),
        .ovf_o      (overflow_o),
        .unf_o      (underflow_o)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rnm_lookup #(
            .NUM_GLOBAL  (NUM_GLOBAL),
            .NUM_STACKED (NUM_STACKED),
            .IW          (IW)
        ) u_lookup (
            .lreg_i    (lk_lreg_i[p*IW +: IW]),
            .base_i    (base),
            .size_i    (size),
            .preg_o    (lk_preg_o[p*IW +: IW]),
            .illegal_o (lk_illegal_o[p])
        );
    end

    assign cfm_o = MARKER_W'({base, locs, size});
endmodule

// File: rtl/rnm_frame_renamer_chk.sv
`timescale 1ns/1ps
module rnm_frame_renamer_chk
    import rnm_pkg::*;
#(
    parameter int NUM_REGS   = 128,
    parameter int NUM_GLOBAL = 32,
    parameter int NUM_PORTS  = 2,
    parameter int MARKER_W   = 64,
    localparam int IW        = $clog2(NUM_REGS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              cmd_op_i,
    input logic [IW-1:0]           cmd_size_i,
    input logic [IW-1:0]           cmd_locals_i,
    input logic [NUM_PORTS*IW-1:0] lk_lreg_i,
    input logic [NUM_PORTS*IW-1:0] lk_preg_o,
    input logic [NUM_PORTS-1:0]    lk_illegal_o,
    input logic [MARKER_W-1:0]     cfm_o,
    input logic                    overflow_o,
    input logic                    underflow_o
);
    localparam logic [IW-1:0] G_IDX   = IW'(NUM_GLOBAL);
    localparam logic [IW-1:0] STK_MAX = IW'(NUM_REGS - NUM_GLOBAL);

    logic [IW-1:0] f_size, f_loc;
    logic          alloc_good;
    assign f_size     = cfm_o[IW-1:0];
    assign f_loc      = cfm_o[2*IW-1:IW];
    assign alloc_good = (cmd_locals_i <= cmd_size_i) && (cmd_size_i <= STK_MAX);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        a_r1_global_identity: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_lreg_i[p*IW +: IW] < G_IDX) |->
            (lk_preg_o[p*IW +: IW] == lk_lreg_i[p*IW +: IW] && !lk_illegal_o[p]));
        a_r3_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
            lk_illegal_o[p] |-> (lk_preg_o[p*IW +: IW] == '0));
        a_r2_stacked_range: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_lreg_i[p*IW +: IW] >= G_IDX && !lk_illegal_o[p]) |->
            (lk_preg_o[p*IW +: IW] >= G_IDX));
    end

    a_r4_alloc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == OP_ALLOC && alloc_good) |=>
        (f_size == $past(cmd_size_i) && f_loc == $past(cmd_locals_i)));
    a_r5_alloc_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == OP_ALLOC && !alloc_good) |=> $stable(cfm_o));
    a_r6_call_size: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == OP_CALL) |=>
        (overflow_o || (f_loc == '0 && f_size == $past(f_size - f_loc))));
    a_r8_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $stable(cfm_o));
    a_r9_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $stable(cfm_o));
    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> ($past(cmd_op_i) == OP_CALL));
    a_r9_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow_o) |-> ($past(cmd_op_i) == OP_RET));
    a_r11_nop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == OP_NOP) |=> $stable(cfm_o));
endmodule

bind rnm_frame_renamer rnm_frame_renamer_chk #(
    .NUM_REGS   (NUM_REGS),
    .NUM_GLOBAL (NUM_GLOBAL),
    .NUM_PORTS  (NUM_PORTS),
    .MARKER_W   (MARKER_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_op_i     (cmd_op_i),
    .cmd_size_i   (cmd_size_i),
    .cmd_locals_i (cmd_locals_i),
    .lk_lreg_i    (lk_lreg_i),
    .lk_preg_o    (lk_preg_o),
    .lk_illegal_o (lk_illegal_o),
    .cfm_o        (cfm_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
);

// File: tb/rnm_frame_renamer_tb.sv
`timescale 1ns/1ps
module rnm_frame_renamer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_r = 2'd0;
    logic [6:0]  size_r = '0;
    logic [6:0]  loc_r = '0;
    logic [6:0]  lreg0 = '0, lreg1 = '0;
    logic [13:0] preg;
    logic [1:0]  ill;
    logic [63:0] cfm;
    logic        ovf, unf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_base = 0, m_size = 0, m_loc = 0, m_cnt = 0;
    int s_base [8];
    int s_size [8];
    int s_loc  [8];
    int saved  [96];

    always #4 clk = ~clk;

    rnm_frame_renamer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_op_i     (op_r),
        .cmd_size_i   (size_r),
        .cmd_locals_i (loc_r),
        .lk_lreg_i    ({lreg1, lreg0}),
        .lk_preg_o    (preg),
        .lk_illegal_o (ill),
        .cfm_o        (cfm),
        .overflow_o   (ovf),
        .underflow_o  (unf)
    );

    function automatic int exp_phys(int r);
        if (r < 32) return r;
        if (r - 32 >= m_size) return 0;
        return 32 + ((m_base + r - 32) % 96);
    endfunction

    function automatic int exp_ill(int r);
        return (r >= 32 && r - 32 >= m_size) ? 1 : 0;
    endfunction

    task automatic chk(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_cfm(string req);
        longint e;
        e = longint'(m_base) * 16384 + longint'(m_loc) * 128 + longint'(m_size);
        chk(req, longint'(cfm), e);
    endtask

    task automatic sweep();
        for (int r = 0; r < 128; r++) begin
            lreg0 = 7'(r);
            lreg1 = 7'(127 - r);
            #1;
            if (r < 32) chk("R1 global identity", longint'(preg[6:0]), r);
            else if (exp_ill(r) == 1) chk("R3 beyond frame", longint'(preg[6:0]), 0);
            else chk("R2 stacked map", longint'(preg[6:0]), exp_phys(r));
            chk("R3 illegal flag", longint'(ill[0]), exp_ill(r));
            chk("R2 port1 map", longint'(preg[13:7]), exp_phys(127 - r));
            chk("R3 port1 flag", longint'(ill[1]), exp_ill(127 - r));
        end
    endtask

    task automatic cmd(logic [1:0] op, int s, int l);
        @(negedge clk);
        op_r = op; size_r = 7'(s); loc_r = 7'(l);
        @(negedge clk);
        op_r = 2'd0;
    endtask

    task automatic do_alloc(int s, int l);
        cmd(2'd3, s, l);
        if (l <= s && s <= 96) begin
            m_size = s; m_loc = l;
        end
    endtask

    task automatic do_call(string req);
        int n;
        n = m_size - m_loc;
        for (int k = 0; k < n; k++) begin
            lreg0 = 7'(32 + m_loc + k); #1; saved[k] = int'(preg[6:0]);
        end
        cmd(2'd1, 0, 0);
        if (m_cnt == 8) begin
            chk("R8 overflow pulse", longint'(ovf), 1);
            chk_cfm("R8 marker held");
            @(negedge clk);
            chk("R8 overflow one cycle", longint'(ovf), 0);
        end else begin
            s_base[m_cnt] = m_base; s_size[m_cnt] = m_size; s_loc[m_cnt] = m_loc;
            m_cnt++;
            m_base = (m_base + m_loc) % 96;
            m_size = n; m_loc = 0;
            chk_cfm(req);
            chk("R6 no overflow", longint'(ovf), 0);
            for (int k = 0; k < n; k++) begin
                lreg0 = 7'(32 + k); #1;
                chk("R6 outputs become inputs", longint'(preg[6:0]), saved[k]);
            end
        end
    endtask

    task automatic do_ret();
        cmd(2'd2, 0, 0);
        if (m_cnt == 0) begin
            chk("R9 underflow pulse", longint'(unf), 1);
            chk_cfm("R9 marker held");
            @(negedge clk);
            chk("R9 underflow one cycle", longint'(unf), 0);
        end else begin
            m_cnt--;
            m_base = s_base[m_cnt]; m_size = s_size[m_cnt]; m_loc = s_loc[m_cnt];
            chk_cfm("R7 return restores");
            chk("R7 no underflow", longint'(unf), 0);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_cfm("R10 reset marker");
        chk("R10 reset ovf", longint'(ovf), 0);
        chk("R10 reset unf", longint'(unf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        sweep();

        do_alloc(20, 8);
        chk_cfm("R4 allocate loads");
        chk("R4 reserved bits", longint'(cfm[63:21]), 0);
        sweep();

        do_alloc(10, 12);
        chk_cfm("R5 locals over size ignored");
        do_alloc(97, 0);
        chk_cfm("R5 size over 96 ignored");
        sweep();

        // R11: the lookup holds the old mapping until the edge
        @(negedge clk);
        op_r = 2'd3; size_r = 7'd24; loc_r = 7'd10; lreg0 = 7'd54;
        #1;
        chk("R11 before edge illegal", longint'(ill[0]), 1);
        chk("R11 before edge phys", longint'(preg[6:0]), 0);
        @(negedge clk);
        op_r = 2'd0;
        m_size = 24; m_loc = 10;
        #1;
        chk("R11 after edge phys", longint'(preg[6:0]), 54);
        chk_cfm("R4 allocate after edge");

        for (int lvl = 0; lvl < 8; lvl++) begin
            do_call("R6 call marker");
            sweep();
            do_alloc(30 + 3 * lvl, 20 + lvl);
            chk_cfm("R4 nested allocate");
            sweep();
        end
        do_call("R8 overflow");
        sweep();

        for (int i = 0; i < 8; i++) begin
            do_ret();
            sweep();
        end
        do_ret();
        sweep();

        // full-frame boundary
        do_alloc(96, 96);
        chk_cfm("R4 full frame");
        sweep();
        do_call("R6 call with no outputs");
        sweep();
        do_ret();
        sweep();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule